// File: doc/BRIEF.md
# DDC Snoop and Termination Controller

This block listens, without ever driving the lines, to the display data channel (an I2C bus) that runs from a video source to its sink. It follows every transaction aimed at one target device and keeps track of that device's register pointer. Whenever a byte at one register offset is written or read, it looks at one bit of that byte. That bit tells whether the link runs in its high-rate clock mode. The block mirrors the bit in a mode flag. From that flag and a termination mode field set by software, it produces the termination code that goes to the transmitter's analog line termination.

Software reaches a single control byte through a simple write strobe and a read-back bus. The byte holds a slew field, the termination mode, a bridge speed select, the mode flag and a snoop-disable bit. The speed and slew fields are only stored here. Their circuits live elsewhere.

The bus monitor is a state machine with these states: MON_IDLE, MON_ADDR, MON_ADDR_ACK, MON_OFFS, MON_OFFS_ACK, MON_WDATA, MON_WDATA_ACK, MON_RDATA, MON_RDATA_ACK and MON_SKIP.
- A START from any state enters MON_ADDR. A STOP from any state enters MON_IDLE.
- In each byte state, the eighth rising SCL moves the machine to the matching ACK state.
- In an ACK state, a high SDA (NACK) on the next rising SCL leads to MON_SKIP.
- An ACKed address leads to MON_OFFS if it is the write address, to MON_RDATA if it is the read address, and to MON_SKIP otherwise.
- An ACKed offset or write byte leads to MON_WDATA. An ACKed read byte leads to MON_RDATA.

A hot-plug-detect input that stays low past a timed window clears the flag.

Top module: `ddc_snoop_ctrl`

## Requirements
- R1: After reset the control byte reads 8'h50: slew [7:6]=01, reserved [5]=0, termination mode [4:3]=10, speed [2]=0, mode flag [1]=0, disable [0]=0.
- R2: A write of a byte with bit 1 set, to address 8'hA8 at pointer 8'h20, sets the mode flag. When the flag goes from 0 to 1 this way, the termination mode field becomes 2'b11.
- R3: A write of a byte with bit 1 clear, to 8'hA8 at pointer 8'h20, clears the mode flag and leaves the termination field unchanged.
- R4: A read from address 8'hA9 at pointer 8'h20 whose data byte has bit 1 set sets the flag. A read whose bit 1 is clear leaves the flag unchanged.
- R5: The first byte after the write address loads the pointer. The pointer then advances by one after every data byte, written or read.
- R6: A transaction whose address byte is NACKed (SDA high in the ninth bit) changes nothing until the next START.
- R7: Traffic to any other address, or to any other pointer value, has no effect.
- R8: When hot-plug-detect has been low for more than CLK_HZ/1000*HPD_MS cycles in a row, the flag is cleared. A shorter low period has no effect.
- R9: `term_code` equals the termination field for field values 00 (150–300 ohm), 01 (none) and 11 (75–150 ohm). For field value 10 it is 11 when the flag is 1 and 01 when the flag is 0.
- R10: A host write that sets the disable bit while it was 0 clears the flag. While the disable bit is 1, snooping has no effect and the flag takes the value host-written to bit 1.
- R11: A host write that clears the disable bit does not restore the termination field. From then on, snooping updates the flag again.
- R12: A host write stores bits [7:6], [4:3], [2] and [0]. Bit 5 always reads 0. Bit 1 is not stored while the disable bit is being written as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Monitored bus clock line |
| sda_in | input | 1 | Monitored bus data line |
| hpd_in | input | 1 | Hot-plug-detect level, high when a sink is attached |
| host_we | input | 1 | Host write strobe for the control byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Current control byte |
| term_code | output | 2 | Effective termination code |

## Verification
On every cycle, the assertions check the following:
- a flag rise caused by the snoop always brings the termination field to 11;
- the flag never rises without either a snoop event or a host write;
- the flag is cleared in the cycle after a hot-plug timeout;
- while disabled, the flag stays stable unless the host writes it;
- the termination code follows a fixed termination field.

Only the bench scenarios can show how bus sequences are decoded. This covers pointer tracking across repeated STARTs, auto-increment, NACK aborts and unrelated addresses. The scenarios also show the exact length of the hot-plug window and how field values are ordered across the disable and re-enable sequence.

// File: rtl/ddc_snoop_pkg.sv
package ddc_snoop_pkg;

    typedef enum logic [3:0] {
        MON_IDLE,
        MON_ADDR,
        MON_ADDR_ACK,
        MON_OFFS,
        MON_OFFS_ACK,
        MON_WDATA,
        MON_WDATA_ACK,
        MON_RDATA,
        MON_RDATA_ACK,
        MON_SKIP
    } mon_state_t;

    localparam logic [1:0] TERM_WIDE  = 2'b00;
    localparam logic [1:0] TERM_NONE  = 2'b01;
    localparam logic [1:0] TERM_AUTO  = 2'b10;
    localparam logic [1:0] TERM_TIGHT = 2'b11;

endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
    parameter int   WIDTH   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[i]     <= RST_VAL;
                sync_out[i] <= RST_VAL;
            end else begin
                meta[i]     <= async_in[i];
                sync_out[i] <= meta[i];
            end
        end
    end
endmodule

// File: rtl/ddc_bus_monitor.sv
module ddc_bus_monitor
    import ddc_snoop_pkg::*;
#(
    parameter logic [7:0] TGT_ADDR = 8'hA8,
    parameter logic [7:0] TGT_OFFS = 8'h20,
    parameter int         TGT_BIT  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic evt_set,
    output logic evt_clr
);
    localparam logic [2:0] BIT_IDX  = 3'(TGT_BIT);
    localparam logic [7:0] RD_ADDR  = {TGT_ADDR[7:1], 1'b1};

    logic [1:0] lines_s;
    logic       scl_s, sda_s, scl_d, sda_d;
    logic       scl_rise, bus_start, bus_stop;
    logic [2:0] bit_cnt;
    logic [7:0] shreg, byte_nxt, addr_q, ptr;
    logic       last_bit;
    mon_state_t state, state_nxt;

    ddc_line_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
    assign byte_nxt  = {shreg[6:0], sda_s};
    assign last_bit  = (bit_cnt == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MON_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (bus_start) begin
            state_nxt = MON_ADDR;
        end else if (bus_stop) begin
            state_nxt = MON_IDLE;
        end else if (scl_rise) begin
            unique case (state)
                MON_IDLE, MON_SKIP: state_nxt = state;
                MON_ADDR:      if (last_bit) state_nxt = MON_ADDR_ACK;
                MON_ADDR_ACK: begin
                    if (sda_s)                   state_nxt = MON_SKIP;
                    else if (addr_q == TGT_ADDR) state_nxt = MON_OFFS;
                    else if (addr_q == RD_ADDR)  state_nxt = MON_RDATA;
                    else                         state_nxt = MON_SKIP;
                end
                MON_OFFS:      if (last_bit) state_nxt = MON_OFFS_ACK;
                MON_OFFS_ACK:  state_nxt = sda_s ? MON_SKIP : MON_WDATA;
                MON_WDATA:     if (last_bit) state_nxt = MON_WDATA_ACK;
                MON_WDATA_ACK: state_nxt = sda_s ? MON_SKIP : MON_WDATA;
                MON_RDATA:     if (last_bit) state_nxt = MON_RDATA_ACK;
                MON_RDATA_ACK: state_nxt = sda_s ? MON_SKIP : MON_RDATA;
                default:       state_nxt = MON_IDLE;
            endcase
        end
    end

    // datapath and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            addr_q  <= '0;
            ptr     <= '0;
            evt_set <= 1'b0;
            evt_clr <= 1'b0;
        end else begin
            evt_set <= 1'b0;
            evt_clr <= 1'b0;
            if (bus_start) begin
                bit_cnt <= '0;
            end else if (scl_rise && (state inside {MON_ADDR, MON_OFFS, MON_WDATA, MON_RDATA})) begin
                shreg   <= byte_nxt;
                bit_cnt <= bit_cnt + 3'd1;
                if (last_bit) begin
                    unique case (state)
                        MON_ADDR: addr_q <= byte_nxt;
                        MON_OFFS: ptr    <= byte_nxt;
                        MON_WDATA: begin
                            ptr <= ptr + 8'd1;
                            if (ptr == TGT_OFFS) begin
                                evt_set <= byte_nxt[BIT_IDX];
                                evt_clr <= ~byte_nxt[BIT_IDX];
                            end
                        end
                        MON_RDATA: begin
                            ptr <= ptr + 8'd1;
                            if (ptr == TGT_OFFS && byte_nxt[BIT_IDX]) evt_set <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ddc_hpd_timer.sv
module ddc_hpd_timer #(
    parameter int LIMIT = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hpd_in,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT + 1);

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  low_cnt <= '0;
        else if (hpd_in)             low_cnt <= '0;
        else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
    end

    assign expired = (low_cnt == CNT_MAX);
endmodule

// File: rtl/ddc_snoop_ctrl.sv
module ddc_snoop_ctrl
    import ddc_snoop_pkg::*;
#(
    parameter int         CLK_HZ   = 200_000_000,
    parameter int         HPD_MS   = 2,
    parameter logic [7:0] TGT_ADDR = 8'hA8,
    parameter logic [7:0] TGT_OFFS = 8'h20,
    parameter int         TGT_BIT  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       hpd_in,
    input  logic       host_we,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic [1:0] term_code
);
    localparam int HPD_LIMIT = CLK_HZ / 1000 * HPD_MS;

    logic       snoop_set, snoop_clr, hpd_expired;
    logic [1:0] slew_q, term_q;
    logic       speed_q, flag_q, dis_q;

    ddc_bus_monitor #(.TGT_ADDR(TGT_ADDR), .TGT_OFFS(TGT_OFFS), .TGT_BIT(TGT_BIT)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .evt_set (snoop_set),
        .evt_clr (snoop_clr)
    );

    ddc_hpd_timer #(.LIMIT(HPD_LIMIT)) u_hpd (
        .clk     (clk),
        .rst_n   (rst_n),
        .hpd_in  (hpd_in),
        .expired (hpd_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slew_q  <= 2'b01;
            term_q  <= TERM_AUTO;
            speed_q <= 1'b0;
            flag_q  <= 1'b0;
            dis_q   <= 1'b0;
        end else begin
            if (host_we) begin
                slew_q  <= host_wdata[7:6];
                term_q  <= host_wdata[4:3];
                speed_q <= host_wdata[2];
                dis_q   <= host_wdata[0];
                if (host_wdata[0]) flag_q <= dis_q ? host_wdata[1] : 1'b0;
            end else if (!dis_q && snoop_set) begin
                flag_q <= 1'b1;
                if (!flag_q) term_q <= TERM_TIGHT;
            end else if (!dis_q && snoop_clr) begin
                flag_q <= 1'b0;
            end
            if (hpd_expired) flag_q <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = {slew_q, 1'b0, term_q, speed_q, flag_q, dis_q};
        term_code  = (term_q == TERM_AUTO) ? (flag_q ? TERM_TIGHT : TERM_NONE) : term_q;
    end
endmodule

// File: rtl/ddc_snoop_chk.sv
module ddc_snoop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_we,
    input logic [7:0] host_rdata,
    input logic [1:0] term_code,
    input logic       snoop_set,
    input logic       snoop_clr,
    input logic       hpd_expired
);
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_set && snoop_clr)); // R3

    AST_AUTO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(host_rdata[1]) && host_rdata[1] && !$past(host_we)) |-> host_rdata[4:3] == 2'b11); // R2

    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !snoop_set) |=> !$rose(host_rdata[1])); // R4

    AST_HPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_expired |=> !host_rdata[1]); // R8

    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[0] && !host_we && !hpd_expired) |=> $stable(host_rdata[1])); // R10

    AST_TERM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[4:3] != 2'b10) |-> term_code == host_rdata[4:3]); // R9
endmodule

bind ddc_snoop_ctrl ddc_snoop_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .host_rdata  (host_rdata),
    .term_code   (term_code),
    .snoop_set   (snoop_set),
    .snoop_clr   (snoop_clr),
    .hpd_expired (hpd_expired)
);

// File: tb/ddc_snoop_ctrl_test.sv
module ddc_snoop_ctrl_test;
    localparam int CLK_HZ = 2_000_000;
    localparam int LIMIT  = CLK_HZ / 1000 * 2;
    localparam int Q      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, hpd = 1'b1;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [1:0] term_code;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ddc_snoop_ctrl #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .hpd_in(hpd),
        .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .term_code(term_code)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda = 1'b1; wait_q(1); scl = 1'b1; wait_q(1); sda = 1'b0; wait_q(1); scl = 1'b0; wait_q(1);
    endtask

    task automatic i2c_stop();
        sda = 1'b0; wait_q(1); scl = 1'b1; wait_q(1); sda = 1'b1; wait_q(2);
    endtask

    task automatic i2c_bit(input logic b);
        sda = b; wait_q(1); scl = 1'b1; wait_q(2); scl = 1'b0; wait_q(1);
    endtask

    task automatic i2c_byte(input logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) i2c_bit(v[i]);
        i2c_bit(nack);
    endtask

    task automatic snoop_wr(input logic [7:0] addr, input logic [7:0] offs, input logic [7:0] d);
        i2c_start(); i2c_byte(addr, 1'b0); i2c_byte(offs, 1'b0); i2c_byte(d, 1'b0); i2c_stop();
        wait_q(2);
    endtask

    task automatic snoop_rd(input logic [7:0] offs, input logic [7:0] d);
        i2c_start(); i2c_byte(8'hA8, 1'b0); i2c_byte(offs, 1'b0);
        i2c_start(); i2c_byte(8'hA9, 1'b0); i2c_byte(d, 1'b1); i2c_stop();
        wait_q(2);
    endtask

    task automatic host_wr(input logic [7:0] v);
        @(negedge clk); host_we = 1'b1; host_wdata = v;
        @(negedge clk); host_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset byte", host_rdata, 8'h50);
        chk("R9 auto code flag0", {6'd0, term_code}, 8'h01);
    endtask

    task automatic t_write();
        snoop_wr(8'hA8, 8'h20, 8'h02);
        chk("R2 write one", host_rdata, 8'h5A);
        chk("R9 code 11", {6'd0, term_code}, 8'h03);
        snoop_wr(8'hA8, 8'h20, 8'hFD);
        chk("R3 write zero", host_rdata, 8'h58);
        host_wr(8'h50);
        chk("R9 restore auto", {6'd0, term_code}, 8'h01);
    endtask

    task automatic t_read();
        snoop_wr(8'hA8, 8'h20, 8'h02);
        host_wr(8'h52);
        chk("R9 auto code flag1", {6'd0, term_code}, 8'h03);
        snoop_rd(8'h20, 8'hFD);
        chk("R4 read zero keeps", host_rdata, 8'h52);
        snoop_wr(8'hA8, 8'h20, 8'h00);
        chk("R3 clear in auto", host_rdata, 8'h50);
        snoop_rd(8'h20, 8'h02);
        chk("R4 read one", host_rdata, 8'h5A);
        snoop_wr(8'hA8, 8'h20, 8'h00);
        host_wr(8'h50);
    endtask

    task automatic t_incr();
        i2c_start(); i2c_byte(8'hA8, 1'b0); i2c_byte(8'h1F, 1'b0);
        i2c_byte(8'h02, 1'b0);
        i2c_byte(8'h00, 1'b0);
        i2c_stop(); wait_q(2);
        chk("R5 no hit at 1F", host_rdata, 8'h50);
        i2c_start(); i2c_byte(8'hA8, 1'b0); i2c_byte(8'h1F, 1'b0);
        i2c_byte(8'h00, 1'b0); i2c_byte(8'h02, 1'b0); i2c_stop(); wait_q(2);
        chk("R5 incremented pointer", host_rdata, 8'h5A);
        snoop_wr(8'hA8, 8'h20, 8'h00);
        host_wr(8'h50);
    endtask

    task automatic t_nack_other();
        i2c_start(); i2c_byte(8'hA8, 1'b1); i2c_byte(8'h20, 1'b0); i2c_byte(8'h02, 1'b0); i2c_stop();
        wait_q(2);
        chk("R6 nack address", host_rdata, 8'h50);
        snoop_wr(8'hA0, 8'h20, 8'h02);
        chk("R7 other address", host_rdata, 8'h50);
        snoop_wr(8'hA8, 8'h21, 8'h02);
        chk("R7 other offset", host_rdata, 8'h50);
    endtask

    task automatic t_term_map();
        host_wr(8'h40);
        chk("R9 field 00", {6'd0, term_code}, 8'h00);
        host_wr(8'h48);
        chk("R9 field 01", {6'd0, term_code}, 8'h01);
        host_wr(8'h58);
        chk("R9 field 11", {6'd0, term_code}, 8'h03);
        host_wr(8'h50);
    endtask

    task automatic t_hpd();
        snoop_wr(8'hA8, 8'h20, 8'h02);
        host_wr(8'h50);
        chk("R12 flag kept when enabled", host_rdata, 8'h52);
        @(negedge clk); hpd = 1'b0;
        repeat (LIMIT - 100) @(negedge clk);
        hpd = 1'b1; repeat (4) @(negedge clk);
        chk("R8 short low", host_rdata, 8'h52);
        hpd = 1'b0;
        repeat (LIMIT + 100) @(negedge clk);
        hpd = 1'b1; repeat (4) @(negedge clk);
        chk("R8 long low", host_rdata, 8'h50);
        chk("R8 code after timeout", {6'd0, term_code}, 8'h01);
    endtask

    task automatic t_disable();
        snoop_wr(8'hA8, 8'h20, 8'h02);
        host_wr(8'h5B);
        chk("R10 disable clears flag", host_rdata, 8'h59);
        snoop_wr(8'hA8, 8'h20, 8'h02);
        chk("R10 snoop ignored", host_rdata, 8'h59);
        host_wr(8'h5B);
        chk("R10 software flag", host_rdata, 8'h5B);
        host_wr(8'h59);
        host_wr(8'h58);
        chk("R11 field not restored", host_rdata, 8'h58);
        snoop_wr(8'hA8, 8'h20, 8'h02);
        chk("R11 snoop resumes", host_rdata, 8'h5A);
        snoop_wr(8'hA8, 8'h20, 8'h00);
        host_wr(8'h50);
    endtask

    task automatic t_layout();
        host_wr(8'hE6);
        chk("R12 field layout", host_rdata, 8'hC4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_incr();
        t_nack_other();
        t_term_map();
        t_hpd();
        t_disable();
        t_layout();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule